// File: doc/BRIEF.md
# Amplifier Protection Fault Controller

This block supervises the output stage of a two-channel switching audio amplifier. It reads a shutdown request (active low), a pair of temperature comparator flags that together form a hysteresis band, a short-circuit comparator flag and the signed differential duty cycle of every channel. From these it chooses one of three output drive modes (running, muted low-power, or high impedance) and drives an active-low fault pin.

Each protection has its own clear rule:

- An over-temperature condition releases itself once the die has cooled through the hysteresis band, and it never shows on the fault pin.
- A short-circuit latch clears when the shutdown input is taken low. Wiring the fault pin back to the shutdown input therefore gives automatic retry.
- A sustained DC imbalance on any channel sets a latch that only a power-on reset removes.

The DC imbalance timer counts ticks from an internal clock divider. The default settings give a one-millisecond tick at 100 MHz and a 420-tick window.

Top module: `amp_guard`

## Requirements
- R1: While `rst` is high, `out_mode` is high impedance (2'b10), `out_en` is 0 and `fault_n` is 1. After `rst` is released with `shdn_n` high and all flags clear, `out_mode` is running (2'b00) and `out_en` is 1.
- R2: With no fault or thermal condition, `shdn_n` low gives `out_mode` muted low-power (2'b01) and `out_en` 0, and leaves `fault_n` at 1.
- R3: `temp_over` high at a clock edge sets the thermal condition, which forces `out_mode` to 2'b10. The condition stays set while `temp_over` is low and `temp_safe` is low. It clears at the first edge where `temp_safe` is high and `temp_over` is low.
- R4: The thermal condition never drives `fault_n` low.
- R5: `short_det` high at an edge where `shdn_n` is high sets the short latch. The latch drives `fault_n` to 0 and `out_mode` to 2'b10, and it holds after `short_det` falls.
- R6: Any edge with `shdn_n` low clears the short latch, and `short_det` is ignored while `shdn_n` is low. With `shdn_n` driven from `fault_n`, a one-cycle short pulse gives `fault_n` low for exactly one cycle, and then the outputs run again.
- R7: Channel k uses bits [k*DATA_W +: DATA_W] of `duty_diff` as a two's complement value. It is imbalanced positive when the value is above IMB_THR and negative when it is below -IMB_THR. A value equal to ±IMB_THR never counts.
- R8: A channel trips when it stays imbalanced with the same sign for more than WIN_TICKS ticks, where one tick is TICK_DIV clock cycles. A hold of WIN_TICKS*TICK_DIV cycles does not trip. A hold of (WIN_TICKS+2)*TICK_DIV cycles does trip.
- R9: A channel's timer restarts whenever its imbalance drops to or inside the threshold, or when its sign changes.
- R10: A DC trip sets a latch that drives `fault_n` to 0 and `out_mode` to 2'b10. Toggling `shdn_n` does not clear it; only `rst` does.
- R11: The drive mode is chosen in this order: reset, then the DC latch, the short latch and the thermal condition (all of which give 2'b10), then shutdown (2'b01), then running (2'b00). `out_en` is 1 only in running mode. `fault_n` is low exactly when the DC latch or the short latch is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| shdn_n | input | 1 | Shutdown request, active low |
| temp_over | input | 1 | Die temperature above trip point |
| temp_safe | input | 1 | Die temperature below trip point minus hysteresis |
| short_det | input | 1 | Output overcurrent comparator |
| duty_diff | input | NCH*DATA_W | Signed differential duty per channel |
| out_en | output | 1 | Output stage enabled (running) |
| out_mode | output | 2 | Drive mode: 00 run, 01 mute, 10 high impedance |
| fault_n | output | 1 | Active-low fault pin |

## Verification
The hardest situation to reach from the ports is the exact edge of the DC window. The tick phase runs freely and is not visible, so the bench cannot aim at a single tick. Instead it holds imbalance for durations whose possible tick counts fall entirely below or entirely above the limit. A sweep over every duty value of one channel then settles the threshold, including the ±IMB_THR points. A second sweep first builds up every combination of DC latch, short latch, thermal condition and shutdown level, and then checks the priority order.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_MUTE = 2'b01,
        MODE_HIZ  = 2'b10
    } drive_mode_e;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_POS  = 2'b01,
        POL_NEG  = 2'b10
    } imb_pol_e;

    typedef struct packed {
        logic dc;
        logic sc;
        logic th;
    } fault_set_t;

    function automatic imb_pol_e classify(input logic signed [31:0] v,
                                          input logic signed [31:0] thr);
        if (v > thr)       return POL_POS;
        else if (v < -thr) return POL_NEG;
        else               return POL_NONE;
    endfunction

    function automatic drive_mode_e pick_mode(input logic por,
                                              input fault_set_t f,
                                              input logic shdn_n);
        if (por)                       return MODE_HIZ;
        else if (f.dc || f.sc || f.th) return MODE_HIZ;
        else if (!shdn_n)              return MODE_MUTE;
        else                           return MODE_RUN;
    endfunction

endpackage

// File: rtl/amp_guard_tick.sv
module amp_guard_tick #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || div_q == LAST) div_q <= '0;
        else                      div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/amp_guard_dcdet.sv
module amp_guard_dcdet
    import amp_guard_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int IMB_THR   = 18,
    parameter int WIN_TICKS = 420
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] diff,
    output logic              trip
);
    localparam int CW = $clog2(WIN_TICKS + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_TICKS);

    logic signed [31:0] diff_ext;
    imb_pol_e           pol_now;
    imb_pol_e           pol_q;
    logic [CW-1:0]      cnt_q;
    logic               same;

    assign diff_ext = {{(32-DATA_W){diff[DATA_W-1]}}, diff};
    assign pol_now  = classify(diff_ext, 32'(IMB_THR));
    assign same     = (pol_now != POL_NONE) && (pol_now == pol_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= POL_NONE;
            cnt_q <= '0;
        end else begin
            pol_q <= pol_now;
            if (!same)
                cnt_q <= '0;
            else if (tick && cnt_q != WIN_LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip = same && tick && (cnt_q == WIN_LAST);
endmodule

// File: rtl/amp_guard_latch.sv
module amp_guard_latch
    import amp_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shdn_n,
    input  logic       temp_over,
    input  logic       temp_safe,
    input  logic       short_det,
    input  logic       dc_trip,
    output fault_set_t flt
);
    fault_set_t flt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= '0;
        end else begin
            if (dc_trip) flt_q.dc <= 1'b1;

            if (!shdn_n)        flt_q.sc <= 1'b0;
            else if (short_det) flt_q.sc <= 1'b1;

            if (temp_over)      flt_q.th <= 1'b1;
            else if (temp_safe) flt_q.th <= 1'b0;
        end
    end

    assign flt = flt_q;
endmodule

// File: rtl/amp_guard.sv
module amp_guard
    import amp_guard_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int DATA_W    = 8,
    parameter int IMB_THR   = 18,
    parameter int WIN_TICKS = 420,
    parameter int TICK_DIV  = 100000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shdn_n,
    input  logic                  temp_over,
    input  logic                  temp_safe,
    input  logic                  short_det,
    input  logic [NCH*DATA_W-1:0] duty_diff,
    output logic                  out_en,
    output logic [1:0]            out_mode,
    output logic                  fault_n
);
    logic             tick;
    logic [NCH-1:0]   ch_trip;
    logic             dc_trip;
    fault_set_t       flt;
    drive_mode_e      mode;

    amp_guard_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        amp_guard_dcdet #(
            .DATA_W   (DATA_W),
            .IMB_THR  (IMB_THR),
            .WIN_TICKS(WIN_TICKS)
        ) u_det (
            .clk (clk),
            .rst (rst),
            .tick(tick),
            .diff(duty_diff[k*DATA_W +: DATA_W]),
            .trip(ch_trip[k])
        );
    end

    assign dc_trip = |ch_trip;

    amp_guard_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .shdn_n   (shdn_n),
        .temp_over(temp_over),
        .temp_safe(temp_safe),
        .short_det(short_det),
        .dc_trip  (dc_trip),
        .flt      (flt)
    );

    assign mode     = pick_mode(rst, flt, shdn_n);
    assign out_mode = mode;
    assign out_en   = (mode == MODE_RUN);
    assign fault_n  = !(flt.dc || flt.sc);
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       shdn_n,
    input logic       temp_over,
    input logic       short_det,
    input logic       dc_trip,
    input logic       dc_hold,
    input logic       out_en,
    input logic [1:0] out_mode,
    input logic       fault_n
);
    assert_mute_on_shutdown_R2: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |-> out_mode != 2'b00);

    assert_hot_disables_R3: assert property (@(posedge clk) disable iff (rst)
        temp_over |=> out_mode == 2'b10);

    assert_thermal_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (fault_n && !short_det && !dc_trip) |=> fault_n);

    assert_fault_hiz_R5: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> out_mode == 2'b10);

    assert_short_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (!shdn_n && !dc_hold && !dc_trip) |=> fault_n);

    assert_dc_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        dc_hold |=> (dc_hold && !fault_n));

    assert_run_needs_clear_R11: assert property (@(posedge clk) disable iff (rst)
        out_en |-> (shdn_n && fault_n && out_mode == 2'b00));
endmodule

bind amp_guard amp_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .shdn_n   (shdn_n),
    .temp_over(temp_over),
    .short_det(short_det),
    .dc_trip  (dc_trip),
    .dc_hold  (flt.dc),
    .out_en   (out_en),
    .out_mode (out_mode),
    .fault_n  (fault_n)
);

// File: tb/amp_guard_bench.sv
`timescale 1ns/1ps
module amp_guard_bench;
    localparam int NCH = 2, DW = 8, THR = 18, WIN = 6, DIV = 4;
    localparam int LONG  = (WIN + 2) * DIV;
    localparam int SHORT = WIN * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shdn_drv = 1'b1, tie = 1'b0;
    logic temp_over = 1'b0, temp_safe = 1'b0, short_det = 1'b0;
    logic [NCH*DW-1:0] duty_diff = '0;
    logic shdn_n, out_en, fault_n;
    logic [1:0] out_mode;
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign shdn_n = tie ? fault_n : shdn_drv;

    amp_guard #(.NCH(NCH), .DATA_W(DW), .IMB_THR(THR), .WIN_TICKS(WIN),
                .TICK_DIV(DIV)) u_amp_guard (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .temp_over(temp_over),
        .temp_safe(temp_safe), .short_det(short_det), .duty_diff(duty_diff),
        .out_en(out_en), .out_mode(out_mode), .fault_n(fault_n));

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tie = 1'b0; shdn_drv = 1'b1; temp_over = 1'b0;
        temp_safe = 1'b0; short_det = 1'b0; duty_diff = '0;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic set_ch(input int ch, input int v);
        duty_diff[ch*DW +: DW] = DW'(v);
    endtask

    task automatic trip_dc();
        set_ch(0, 40); cyc(LONG); set_ch(0, 0); cyc(1);
    endtask

    initial begin
        // R1 reset state
        cyc(1);
        chk("R1 mode in reset", 32'(out_mode), 32'd2);
        chk("R1 en in reset", 32'(out_en), 32'd0);
        chk("R1 fault_n in reset", 32'(fault_n), 32'd1);
        do_reset();
        chk("R1 run after reset", 32'(out_mode), 32'd0);
        chk("R1 en after reset", 32'(out_en), 32'd1);

        // R2 shutdown mutes
        shdn_drv = 1'b0; cyc(1);
        chk("R2 mute mode", 32'(out_mode), 32'd1);
        chk("R2 en off", 32'(out_en), 32'd0);
        chk("R2 fault_n high", 32'(fault_n), 32'd1);
        shdn_drv = 1'b1; cyc(1);
        chk("R2 run again", 32'(out_mode), 32'd0);

        // R3 / R4 thermal with hysteresis
        temp_over = 1'b1; cyc(1); temp_over = 1'b0;
        chk("R3 hot hiz", 32'(out_mode), 32'd2);
        chk("R4 hot no fault", 32'(fault_n), 32'd1);
        cyc(5);
        chk("R3 hysteresis hold", 32'(out_mode), 32'd2);
        chk("R4 still no fault", 32'(fault_n), 32'd1);
        temp_safe = 1'b1; cyc(1); temp_safe = 1'b0;
        chk("R3 cooled run", 32'(out_mode), 32'd0);

        // R5 short latch
        short_det = 1'b1; cyc(1); short_det = 1'b0;
        chk("R5 fault_n low", 32'(fault_n), 32'd0);
        chk("R5 hiz", 32'(out_mode), 32'd2);
        cyc(4);
        chk("R5 held", 32'(fault_n), 32'd0);
        // R6 clear via shutdown
        shdn_drv = 1'b0; cyc(1);
        chk("R6 cleared", 32'(fault_n), 32'd1);
        chk("R6 mute", 32'(out_mode), 32'd1);
        short_det = 1'b1; cyc(2); short_det = 1'b0;
        chk("R6 short ignored in shutdown", 32'(fault_n), 32'd1);
        shdn_drv = 1'b1; cyc(1);
        chk("R6 run", 32'(out_mode), 32'd0);
        // R6 auto recovery through tie
        tie = 1'b1;
        short_det = 1'b1; cyc(1); short_det = 1'b0;
        chk("R6 auto fault pulse", 32'(fault_n), 32'd0);
        cyc(1);
        chk("R6 auto recovered", 32'(fault_n), 32'd1);
        chk("R6 auto run", 32'(out_mode), 32'd0);
        tie = 1'b0;

        // R7 / R8 sweep of every left-channel value
        for (int v = -128; v <= 127; v++) begin
            do_reset();
            set_ch(0, v); cyc(LONG); set_ch(0, 0); cyc(1);
            chk($sformatf("R7 sweep v=%0d", v), 32'(fault_n),
                ((v > THR) || (v < -THR)) ? 32'd0 : 32'd1);
        end
        // R8 window boundary both channels
        do_reset();
        set_ch(1, -(THR + 1)); cyc(SHORT); set_ch(1, 0); cyc(1);
        chk("R8 short hold no trip", 32'(fault_n), 32'd1);
        set_ch(1, -(THR + 1)); cyc(LONG); set_ch(1, 0); cyc(1);
        chk("R8 long hold trips ch1", 32'(fault_n), 32'd0);

        // R9 restart on sign change and on gap
        do_reset();
        set_ch(0, 60); cyc(SHORT); set_ch(0, -60); cyc(SHORT); set_ch(0, 0); cyc(1);
        chk("R9 sign flip restarts", 32'(fault_n), 32'd1);
        set_ch(0, 60); cyc(SHORT); set_ch(0, THR); cyc(1);
        set_ch(0, 60); cyc(SHORT); set_ch(0, 0); cyc(1);
        chk("R9 gap restarts", 32'(fault_n), 32'd1);

        // R10 DC latch persists through shutdown
        do_reset();
        trip_dc();
        chk("R10 dc fault", 32'(fault_n), 32'd0);
        shdn_drv = 1'b0; cyc(3); shdn_drv = 1'b1; cyc(2);
        chk("R10 shutdown no clear", 32'(fault_n), 32'd0);
        chk("R10 hiz", 32'(out_mode), 32'd2);
        do_reset();
        chk("R10 reset clears", 32'(fault_n), 32'd1);

        // R11 priority over all combinations
        for (int m = 0; m < 16; m++) begin
            bit d, s, t, sd, scx;
            logic [1:0] em;
            d = m[3]; s = m[2]; t = m[1]; sd = m[0];
            do_reset();
            if (d) trip_dc();
            if (s) begin short_det = 1'b1; cyc(1); short_det = 1'b0; end
            if (t) begin temp_over = 1'b1; cyc(1); temp_over = 1'b0; end
            shdn_drv = sd; cyc(1);
            scx = s && sd;
            em = (d || scx || t) ? 2'd2 : (!sd ? 2'd1 : 2'd0);
            chk($sformatf("R11 mode m=%0d", m), 32'(out_mode), 32'(em));
            chk($sformatf("R11 fault_n m=%0d", m), 32'(fault_n), 32'(!(d || scx)));
            chk($sformatf("R11 en m=%0d", m), 32'(out_en), 32'(em == 2'd0));
        end

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule